// File: doc/BRIEF.md
# Programmable-Priority Interrupt Arbiter

This block chooses which pending exception the processor should take next. It watches a set of maskable interrupt lines, one per peripheral channel, and a small group of system-class exception lines. Every maskable channel has a 3-bit priority level stored in a configuration register inside the block. Level 0 turns a channel off. Level 7 is the most urgent. Each cycle the block compares the pending requests with the processor's current interrupt priority level and its global mask bit. It registers the winner as a valid flag, a vector offset and a priority level for the processor to load.

The system-class lines always rank above every maskable channel. Among themselves they follow a fixed order, and no mask or configuration affects them. While any of them is pending, no maskable channel is offered. A simple write/read port lets software set and inspect each channel's level. An acknowledge input captures the vector the processor is actually given. If the request that had been winning has been withdrawn by the acknowledge cycle, the block hands out a fixed spurious vector instead.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every channel's level reads back as 1; `irq_valid`, `irq_vec`, `irq_lvl`, `ack_vec`, `ack_lvl` and `cfg_rdata` are 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` as the level of channel `cfg_addr`. `cfg_rdata` presents the level of the channel at `cfg_addr` one clock after the address is applied.
- R3: A channel whose level is 0 never wins, even when its request line is high.
- R4: A maskable channel is eligible only if its level is strictly greater than `cpu_ipl`.
- R5: While `cpu_imask` is 1, no maskable channel is offered.
- R6: Among eligible channels the highest level wins. Channel i is reported with `irq_vec` = 4*i and `irq_lvl` equal to its level.
- R7: When several eligible channels share the highest level, the one with the higher index (higher vector) wins.
- R8: While any `sys_req` bit is set, maskable channels are suppressed. Bit 0 has the highest rank. Bit k is reported with `irq_vec` = 0x1F8 - 4*k and `irq_lvl` = 7, regardless of `cpu_imask`, `cpu_ipl` and channel levels.
- R9: `irq_valid`, `irq_vec` and `irq_lvl` reflect the inputs of the previous clock cycle. When `irq_valid` is 0, `irq_vec` and `irq_lvl` are 0.
- R10: On a cycle with `ack` high, `ack_vec`/`ack_lvl` capture that cycle's winner. If nothing is winning, they capture the spurious vector 0x1DC at level 7. They hold until the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_CH | Maskable request lines, already gated by peripheral enables |
| sys_req | input | NSYS | System-class exception requests, bit 0 most urgent |
| cpu_ipl | input | 3 | Processor's current interrupt priority level |
| cpu_imask | input | 1 | Processor's global maskable-interrupt mask |
| ack | input | 1 | Processor acknowledges the offered exception |
| cfg_we | input | 1 | Level register write strobe |
| cfg_addr | input | CH_AW | Channel selected for write and read |
| cfg_wdata | input | 3 | Level to write |
| cfg_rdata | output | 3 | Level of the channel at `cfg_addr`, registered |
| irq_valid | output | 1 | An exception is being offered |
| irq_vec | output | VEC_W | Vector offset of the offered exception |
| irq_lvl | output | 3 | Priority level of the offered exception |
| ack_vec | output | VEC_W | Vector captured at the last acknowledge |
| ack_lvl | output | 3 | Level captured at the last acknowledge |

## Verification
The assertions assume the inputs are synchronous to `clk` and free of X once reset is released. They relate each output to the previous cycle's inputs through `$past`, so they also assume inputs change only once per cycle. The bench meets this by driving every input on the falling edge, holding it across the rising edge, and sampling results one falling edge later. `cfg_addr` always stays below `NUM_CH`. The spurious-vector assertion assumes no request is pending in the acknowledge cycle. The bench exercises that case only with every request line low.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP   = '1;
  localparam lvl_t LVL_RESET = lvl_t'(1);
endpackage

// File: rtl/irq_cfg_regs.sv
// Per-channel priority level storage with a registered read port.
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_AW  = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [CH_AW-1:0]             addr,
  input  lvl_t                         wdata,
  output lvl_t                         rdata,
  output logic [NUM_CH-1:0][LVL_W-1:0] lvls
);
  // Every level feeds the arbiter in parallel, so storage is flops.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        lvls[i] <= LVL_RESET;
      else if (we && addr == CH_AW'(i))
        lvls[i] <= wdata;
    end
  end

  if (NUM_CH == (1 << CH_AW)) begin : g_full
    always_ff @(posedge clk) begin
      if (rst) rdata <= '0;
      else     rdata <= lvls[addr];
    end
  end else begin : g_part
    always_ff @(posedge clk) begin
      if (rst)                        rdata <= '0;
      else if (int'(addr) < NUM_CH)   rdata <= lvls[addr];
      else                            rdata <= '0;
    end
  end
endmodule

// File: rtl/irq_mask_pick.sv
// Picks the highest-level eligible maskable channel; ties go to higher index.
module irq_mask_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]            req,
  input  logic [NUM_CH-1:0][LVL_W-1:0] lvls,
  input  lvl_t                         ipl,
  output logic                         found,
  output logic [IDX_W-1:0]             idx,
  output lvl_t                         lvl
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      // Level above ipl implies a non-zero level.
      if (req[i] && (lvls[i] > ipl) && (!found || lvls[i] >= lvl)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        lvl   = lvls[i];
      end
    end
  end
endmodule

// File: rtl/irq_sys_chain.sv
// Fixed-order encoder for system-class exceptions; bit 0 ranks highest.
module irq_sys_chain #(
  parameter int NSYS    = 7,
  parameter int VEC_W   = 9,
  parameter int SYS_TOP = 'h1F8
) (
  input  logic [NSYS-1:0]  sys_req,
  output logic             any,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    any = |sys_req;
    vec = '0;
    for (int k = NSYS - 1; k >= 0; k--) begin
      if (sys_req[k]) vec = VEC_W'(SYS_TOP - 4 * k);
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NSYS     = 7,
  parameter int VEC_W    = 9,
  parameter int SYS_TOP  = 'h1F8,
  parameter int SPUR_VEC = 'h1DC,
  parameter int CH_AW    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] irq_req,
  input  logic [NSYS-1:0]   sys_req,
  input  logic [2:0]        cpu_ipl,
  input  logic              cpu_imask,
  input  logic              ack,
  input  logic              cfg_we,
  input  logic [CH_AW-1:0]  cfg_addr,
  input  logic [2:0]        cfg_wdata,
  output logic [2:0]        cfg_rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [2:0]        irq_lvl,
  output logic [VEC_W-1:0]  ack_vec,
  output logic [2:0]        ack_lvl
);
  logic [NUM_CH-1:0][LVL_W-1:0] lvls;
  logic                         m_found;
  logic [CH_AW-1:0]             m_idx;
  lvl_t                         m_lvl;
  logic                         s_any;
  logic [VEC_W-1:0]             s_vec;
  logic                         nxt_valid;
  logic [VEC_W-1:0]             nxt_vec;
  lvl_t                         nxt_lvl;

  irq_cfg_regs #(.NUM_CH(NUM_CH), .CH_AW(CH_AW)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .lvls  (lvls)
  );

  irq_mask_pick #(.NUM_CH(NUM_CH), .IDX_W(CH_AW)) u_pick (
    .req   (irq_req),
    .lvls  (lvls),
    .ipl   (cpu_ipl),
    .found (m_found),
    .idx   (m_idx),
    .lvl   (m_lvl)
  );

  irq_sys_chain #(.NSYS(NSYS), .VEC_W(VEC_W), .SYS_TOP(SYS_TOP)) u_sys (
    .sys_req (sys_req),
    .any     (s_any),
    .vec     (s_vec)
  );

  always_comb begin
    nxt_valid = 1'b0;
    nxt_vec   = '0;
    nxt_lvl   = '0;
    if (s_any) begin
      nxt_valid = 1'b1;
      nxt_vec   = s_vec;
      nxt_lvl   = LVL_TOP;
    end else if (!cpu_imask && m_found) begin
      nxt_valid = 1'b1;
      nxt_vec   = VEC_W'({m_idx, 2'b00});
      nxt_lvl   = m_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_lvl   <= '0;
      ack_vec   <= '0;
      ack_lvl   <= '0;
    end else begin
      irq_valid <= nxt_valid;
      irq_vec   <= nxt_vec;
      irq_lvl   <= nxt_lvl;
      if (ack) begin
        ack_vec <= nxt_valid ? nxt_vec : VEC_W'(SPUR_VEC);
        ack_lvl <= nxt_valid ? nxt_lvl : LVL_TOP;
      end
    end
  end
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int NUM_CH   = 8,
  parameter int NSYS     = 7,
  parameter int VEC_W    = 9,
  parameter int SYS_TOP  = 'h1F8,
  parameter int SPUR_VEC = 'h1DC
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] irq_req,
  input logic [NSYS-1:0]   sys_req,
  input logic [2:0]        cpu_ipl,
  input logic              cpu_imask,
  input logic              ack,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vec,
  input logic [2:0]        irq_lvl,
  input logic [VEC_W-1:0]  ack_vec,
  input logic [2:0]        ack_lvl
);
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (irq_vec == '0 && irq_lvl == 3'd0));

  assert_level_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_lvl != 3'd0);

  assert_above_ipl_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !$past(rst) && $past(sys_req) == '0) |-> irq_lvl > $past(cpu_ipl));

  assert_imask_block_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_imask) && $past(sys_req) == '0) |-> !irq_valid);

  assert_sys_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sys_req) != '0) |->
      (irq_valid && irq_lvl == 3'd7 && int'(irq_vec) > SPUR_VEC));

  assert_spurious_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ack) && $past(sys_req) == '0 && $past(irq_req) == '0) |->
      (ack_vec == VEC_W'(SPUR_VEC) && ack_lvl == 3'd7));

  assert_ack_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ack)) |-> ($stable(ack_vec) && $stable(ack_lvl)));
endmodule

bind irq_prio_arbiter irq_arb_checker #(
  .NUM_CH(NUM_CH), .NSYS(NSYS), .VEC_W(VEC_W), .SYS_TOP(SYS_TOP), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .sys_req(sys_req), .cpu_ipl(cpu_ipl),
  .cpu_imask(cpu_imask), .ack(ack), .irq_valid(irq_valid), .irq_vec(irq_vec),
  .irq_lvl(irq_lvl), .ack_vec(ack_vec), .ack_lvl(ack_lvl)
);

// File: tb/tb_irq_prio_arbiter.sv
`timescale 1ns/1ps
module tb_irq_prio_arbiter;
  localparam int NUM_CH = 8;
  localparam int NSYS   = 7;
  localparam int VEC_W  = 9;
  localparam int CH_AW  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] irq_req = '0;
  logic [NSYS-1:0]   sys_req = '0;
  logic [2:0]        cpu_ipl = '0;
  logic              cpu_imask = 1'b0;
  logic              ack = 1'b0;
  logic              cfg_we = 1'b0;
  logic [CH_AW-1:0]  cfg_addr = '0;
  logic [2:0]        cfg_wdata = '0;
  logic [2:0]        cfg_rdata;
  logic              irq_valid;
  logic [VEC_W-1:0]  irq_vec;
  logic [2:0]        irq_lvl;
  logic [VEC_W-1:0]  ack_vec;
  logic [2:0]        ack_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_prio_arbiter dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .sys_req(sys_req), .cpu_ipl(cpu_ipl),
    .cpu_imask(cpu_imask), .ack(ack), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl), .ack_vec(ack_vec), .ack_lvl(ack_lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input int v, input int vec, input int lvl);
    chk({tag, " valid"}, int'(irq_valid), v);
    chk({tag, " vec"},   int'(irq_vec),   vec);
    chk({tag, " lvl"},   int'(irq_lvl),   lvl);
  endtask

  task automatic wr_lvl(input int ch, input int lvl);
    cfg_we = 1'b1; cfg_addr = CH_AW'(ch); cfg_wdata = 3'(lvl);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [NUM_CH-1:0] r, input logic [NSYS-1:0] s,
                       input int ipl, input logic im);
    irq_req = r; sys_req = s; cpu_ipl = 3'(ipl); cpu_imask = im;
    step();
  endtask

  task automatic t_reset();
    step();
    rst = 1'b0;
    expect_out("R1 reset", 0, 0, 0);
    chk("R1 reset ack_vec", int'(ack_vec), 0);
    chk("R1 reset ack_lvl", int'(ack_lvl), 0);
    chk("R1 reset rdata", int'(cfg_rdata), 0);
    for (int i = 0; i < NUM_CH; i++) begin
      cfg_addr = CH_AW'(i);
      step();
      chk($sformatf("R1 reset level ch%0d", i), int'(cfg_rdata), 1);
    end
  endtask

  task automatic t_cfg();
    wr_lvl(2, 5);
    cfg_addr = 3'd2;
    step();
    chk("R2 readback ch2", int'(cfg_rdata), 5);
    wr_lvl(1, 6);
    wr_lvl(5, 4);
    cfg_addr = 3'd5;
    step();
    chk("R2 readback ch5", int'(cfg_rdata), 4);
  endtask

  task automatic t_timing();
    irq_req = 8'b0000_1000;
    #1;
    expect_out("R9 before edge", 0, 0, 0);
    step();
    expect_out("R6 single ch3", 1, 12, 1);
    irq_req = '0;
    #1;
    expect_out("R9 held until edge", 1, 12, 1);
    step();
    expect_out("R9 idle zeros", 0, 0, 0);
  endtask

  task automatic t_highest();
    apply(8'b0010_0010, '0, 0, 1'b0);
    expect_out("R6 highest ch1", 1, 4, 6);
    apply(8'b0010_0001, '0, 0, 1'b0);
    expect_out("R6 ch5 over ch0", 1, 20, 4);
  endtask

  task automatic t_tie();
    wr_lvl(6, 5);
    apply(8'b0100_0100, '0, 0, 1'b0);
    expect_out("R7 tie ch6 over ch2", 1, 24, 5);
  endtask

  task automatic t_disable();
    wr_lvl(6, 0);
    apply(8'b0100_0000, '0, 0, 1'b0);
    expect_out("R3 level0 alone", 0, 0, 0);
    apply(8'b0100_0001, '0, 0, 1'b0);
    expect_out("R3 level0 loses to ch0", 1, 0, 1);
  endtask

  task automatic t_ipl();
    apply(8'b0000_0101, '0, 5, 1'b0);
    expect_out("R4 ipl equal", 0, 0, 0);
    apply(8'b0000_0101, '0, 4, 1'b0);
    expect_out("R4 ipl below", 1, 8, 5);
    apply(8'b0000_0001, '0, 1, 1'b0);
    expect_out("R4 ch0 at ipl1", 0, 0, 0);
  endtask

  task automatic t_imask();
    apply(8'b0000_0100, '0, 0, 1'b1);
    expect_out("R5 imask set", 0, 0, 0);
    apply(8'b0000_0100, '0, 0, 1'b0);
    expect_out("R5 imask clear", 1, 8, 5);
  endtask

  task automatic t_sys();
    apply(8'b0000_0100, 7'b000_1000, 0, 1'b1);
    expect_out("R8 bit3 under imask", 1, 'h1EC, 7);
    apply(8'b0000_0010, 7'b010_0001, 0, 1'b0);
    expect_out("R8 bit0 over bit5", 1, 'h1F8, 7);
    apply('0, 7'b100_0000, 7, 1'b0);
    expect_out("R8 bit6 at ipl7", 1, 'h1E0, 7);
  endtask

  task automatic t_ack();
    irq_req = 8'b0000_0100; sys_req = '0; cpu_ipl = 3'd0; cpu_imask = 1'b0; ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R10 ack vec ch2", int'(ack_vec), 8);
    chk("R10 ack lvl ch2", int'(ack_lvl), 5);
    irq_req = '0;
    step();
    chk("R10 ack held", int'(ack_vec), 8);
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R10 spurious vec", int'(ack_vec), 'h1DC);
    chk("R10 spurious lvl", int'(ack_lvl), 7);
    expect_out("R10 nothing offered", 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cfg();
    t_timing();
    t_highest();
    t_tie();
    t_disable();
    t_ipl();
    t_imask();
    t_sys();
    t_ack();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule